// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block sits in the feedback path of a frequency synthesizer. An external dual-modulus prescaler divides the oscillator by P or P+1. This block is clocked by the prescaler's output and tells the prescaler which modulus to use on each of its periods. Two down-counters work together. The programmable count B sets how many prescaler periods make up one feedback cycle. The swallow count A sets how many of those periods, at the start of the cycle, use the larger modulus. The oscillator is therefore divided by N = P*B + A. One pulse per feedback cycle goes to the phase detector.

The counts and the prescaler-size select are sampled only at a cycle boundary, so software can rewrite them at any time without corrupting a cycle in progress. A power-down input stops the counters and silences both outputs. A test input holds the counters at their load values. The width of A is a parameter: 7 bits for the high-band channel and 4 bits for the low-band channel. B is 11 bits by default. The lower modulus P is 64 (select low) or 128 (select high) on the high-band channel, and 8 or 16 on the low-band channel.

Top module: `swallow_divider`

## Requirements
- R1: With no power-down and no hold, the distance between consecutive `div_o` pulses is exactly B prescaler clocks, where B is the `prog_i` value sampled at the start of that cycle.
- R2: In each feedback cycle, `mod_hi_o` is high for the first A prescaler clocks and low for the remaining clocks. When A = 0 it is low for the whole cycle. In both cases A ≤ B.
- R3: Over one feedback cycle, the sum of (P + `mod_hi_o`) equals P*B + A. P is the lower modulus selected by `wide_sel_o`: 64 when it is 0 and 128 when it is 1 (high-band channel).
- R4: `div_o` is high for exactly one prescaler clock per cycle, as long as B ≥ 3.
- R5: `swallow_i`, `prog_i` and `wide_sel_i` are sampled only on the clock edge that ends a cycle. Changing them in mid-cycle leaves the current cycle's length and modulus pattern unchanged, and `wide_sel_o` changes only at a cycle boundary.
- R6: While `pwr_dn_i` is high, `div_o` and `mod_hi_o` are low. After `pwr_dn_i` is released, the first pulse comes B clocks later.
- R7: While `cnt_hold_i` is high (and power-down is low), no pulse is produced, and `mod_hi_o` equals (A ≠ 0). After release, the first pulse comes B−1 clocks later.
- R8: During reset, `div_o`, `mod_hi_o` and `wide_sel_o` are 0. The first pulse comes B clocks after reset is released.
- R9: The full 7-bit swallow range is honoured: A = 127 with B = 130 gives 127 high-modulus clocks per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pre | input | 1 | Prescaler output, clocks the counters |
| rst_n | input | 1 | Asynchronous active-low reset |
| swallow_i | input | A_W | Swallow count A |
| prog_i | input | B_W | Programmable count B (3 or more) |
| wide_sel_i | input | 1 | Prescaler size request (1 = larger pair) |
| pwr_dn_i | input | 1 | Power-down: counters cleared, outputs low |
| cnt_hold_i | input | 1 | Test hold of both counters at load values |
| mod_hi_o | output | 1 | Modulus control, 1 = divide by P+1 |
| wide_sel_o | output | 1 | Prescaler size, applied at cycle boundary |
| div_o | output | 1 | Divided pulse to the phase detector |

## Verification
A corrupted B counter shows up as a wrong interval between pulses, which is visible at the very next pulse. A corrupted A counter shows up as a wrong number of high modulus-control clocks, or as a late rising edge, within the same cycle. Faults in boundary sampling show up as one cycle running with counts that were written in mid-cycle, or as the size output changing mid-cycle. The bench measures every cycle in full and rebuilds the total P*B+A from the observed modulus line.

// File: rtl/swallow_divider.sv
module swallow_divider #(
  parameter int A_W = 7,
  parameter int B_W = 11
) (
  input  logic           clk_pre,
  input  logic           rst_n,
  input  logic [A_W-1:0] swallow_i,
  input  logic [B_W-1:0] prog_i,
  input  logic           wide_sel_i,
  input  logic           pwr_dn_i,
  input  logic           cnt_hold_i,
  output logic           mod_hi_o,
  output logic           wide_sel_o,
  output logic           div_o
);

  localparam logic [B_W-1:0] B_LAST = B_W'(1);

  logic [B_W-1:0] b_cnt;
  logic [A_W-1:0] a_cnt;
  logic           sel_q;
  logic           reload;

  assign reload = cnt_hold_i || (b_cnt <= B_LAST);

  always_ff @(posedge clk_pre or negedge rst_n) begin
    if (!rst_n) begin
      b_cnt <= '0;
      a_cnt <= '0;
      sel_q <= 1'b0;
    end else if (pwr_dn_i) begin
      b_cnt <= '0;
      a_cnt <= '0;
    end else if (reload) begin
      b_cnt <= prog_i;
      a_cnt <= swallow_i;
      sel_q <= wide_sel_i;
    end else begin
      b_cnt <= b_cnt - B_LAST;
      if (a_cnt != '0) a_cnt <= a_cnt - A_W'(1);
    end
  end

  assign div_o      = !pwr_dn_i && (b_cnt == B_LAST);
  assign mod_hi_o   = !pwr_dn_i && (a_cnt != '0);
  assign wide_sel_o = sel_q;

endmodule

module swallow_divider_chk #(
  parameter int A_W = 7,
  parameter int B_W = 11
) (
  input logic           clk_pre,
  input logic           rst_n,
  input logic [A_W-1:0] swallow_i,
  input logic           pwr_dn_i,
  input logic           cnt_hold_i,
  input logic           mod_hi_o,
  input logic           wide_sel_o,
  input logic           div_o,
  input logic [B_W-1:0] b_cnt
);

  assert_pulse_single_R4: assert property (@(posedge clk_pre) disable iff (!rst_n)
    div_o |=> !div_o);

  assert_pd_quiet_R6: assert property (@(posedge clk_pre) disable iff (!rst_n)
    pwr_dn_i |-> (!div_o && !mod_hi_o));

  assert_hold_no_pulse_R7: assert property (@(posedge clk_pre) disable iff (!rst_n)
    (cnt_hold_i && $past(cnt_hold_i) && !pwr_dn_i && !$past(pwr_dn_i)) |-> !div_o);

  assert_mod_start_R2: assert property (@(posedge clk_pre) disable iff (!rst_n)
    div_o |=> (pwr_dn_i || (mod_hi_o == ($past(swallow_i) != '0))));

  assert_mod_rise_R2: assert property (@(posedge clk_pre) disable iff (!rst_n)
    $rose(mod_hi_o) |-> ($past(div_o) || $past(cnt_hold_i) || ($past(b_cnt) == '0)));

  assert_sel_stable_R5: assert property (@(posedge clk_pre) disable iff (!rst_n)
    ($past(pwr_dn_i) || !($past(cnt_hold_i) || ($past(b_cnt) <= B_W'(1))))
      |-> $stable(wide_sel_o));

endmodule

bind swallow_divider swallow_divider_chk #(.A_W(A_W), .B_W(B_W)) u_chk (
  .clk_pre(clk_pre), .rst_n(rst_n), .swallow_i(swallow_i),
  .pwr_dn_i(pwr_dn_i), .cnt_hold_i(cnt_hold_i), .mod_hi_o(mod_hi_o),
  .wide_sel_o(wide_sel_o), .div_o(div_o), .b_cnt(b_cnt)
);

// File: tb/sim_swallow_divider.sv
module sim_swallow_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  a_v = '0;
  logic [10:0] b_v = 11'd5;
  logic        sel_v = 1'b0;
  logic        pd = 1'b0;
  logic        hold = 1'b0;
  logic        mod_hi, sel_o, div;
  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  swallow_divider u0 (
    .clk_pre(clk), .rst_n(rst_n), .swallow_i(a_v), .prog_i(b_v),
    .wide_sel_i(sel_v), .pwr_dn_i(pd), .cnt_hold_i(hold),
    .mod_hi_o(mod_hi), .wide_sel_o(sel_o), .div_o(div)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wait_pulse(output int n);
    n = 0;
    do begin step(); n++; end while (!div && n < 5000);
  endtask

  task automatic measure(input int eb, input int ea, input int ep, input string tag);
    int c = 0, hi = 0, vs = 0;
    step();
    chk({tag, " R4 pulse width"}, int'(div), 0);
    c = 1; hi = int'(mod_hi); vs = (sel_o ? 128 : 64) + int'(mod_hi);
    while (!div && c < 5000) begin
      step();
      c++; hi += int'(mod_hi); vs += (sel_o ? 128 : 64) + int'(mod_hi);
    end
    chk({tag, " R1 period"}, c, eb);
    chk({tag, " R2 high-modulus count"}, hi, ea);
    chk({tag, " R3 total division"}, vs, ep * eb + ea);
  endtask

  task automatic t_reset();
    int n;
    step();
    chk("R8 div in reset", int'(div), 0);
    chk("R8 mod in reset", int'(mod_hi), 0);
    chk("R8 sel in reset", int'(sel_o), 0);
    a_v = 7'd2; b_v = 11'd5;
    rst_n = 1'b1;
    wait_pulse(n);
    chk("R8 first pulse after reset", n, 5);
  endtask

  task automatic t_patterns();
    measure(5, 2, 64, "basic");
    a_v = 7'd0; b_v = 11'd3;
    measure(3, 0, 64, "A zero B min");
    a_v = 7'd5; b_v = 11'd9; sel_v = 1'b1;
    measure(9, 5, 128, "wide prescaler");
    chk("R3 size output follows", int'(sel_o), 1);
    a_v = 7'd7; b_v = 11'd7; sel_v = 1'b0;
    measure(7, 7, 64, "A equals B");
    a_v = 7'd127; b_v = 11'd130;
    measure(130, 127, 64, "R9 full swallow range");
  endtask

  task automatic t_midcycle();
    int c;
    a_v = 7'd1; b_v = 11'd6; sel_v = 1'b0;
    step(); step();
    a_v = 7'd3; b_v = 11'd10; sel_v = 1'b1;
    c = 2;
    while (!div && c < 5000) begin
      chk("R5 size held mid-cycle", int'(sel_o), 0);
      step(); c++;
    end
    chk("R5 old period kept", c, 6);
    measure(10, 3, 128, "R5 new values next cycle");
    sel_v = 1'b0;
  endtask

  task automatic t_powerdown();
    int n;
    step(); step();
    pd = 1'b1;
    #1;
    chk("R6 div off at once", int'(div), 0);
    for (int i = 0; i < 8; i++) begin
      step();
      chk("R6 div low in power-down", int'(div), 0);
      chk("R6 mod low in power-down", int'(mod_hi), 0);
    end
    pd = 1'b0;
    wait_pulse(n);
    chk("R6 first pulse after power-up", n, 10);
  endtask

  task automatic t_hold();
    int n;
    a_v = 7'd3; b_v = 11'd8;
    hold = 1'b1;
    step();
    for (int i = 0; i < 5; i++) begin
      step();
      chk("R7 no pulse in hold", int'(div), 0);
      chk("R7 mod in hold", int'(mod_hi), 1);
    end
    a_v = 7'd0;
    step(); step();
    chk("R7 mod in hold with A zero", int'(mod_hi), 0);
    a_v = 7'd3;
    step();
    hold = 1'b0;
    wait_pulse(n);
    chk("R7 first pulse after hold", n, 7);
    measure(8, 3, 64, "after hold");
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step(); step();
    t_reset();
    t_patterns();
    t_midcycle();
    t_powerdown();
    t_hold();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule